// File: doc/BRIEF.md
# Programmable Cascaded Clock-Output Divider

This block makes a free-running clock for an output pin from the internal bus clock. Software sets it up through one 8-bit control register on a simple synchronous port: a write strobe with 8-bit write data, and a read-data bus that always shows the register. A 5-bit ratio field selects an integer divide ratio N of field+1, from 1 to 32. A switchable stage after it divides by a further 16, which gives ratios up to 512. A disable bit turns the pin off. The disable bit is set out of reset, so the pin stays quiet until software clears it.

The output comes from a registered phase decode of two cascaded counters, so it does not glitch. While the block is disabled, both counters are held at zero and the pin is held low, so the first edge after enabling comes at a known time. A new ratio or stage setting is adopted only when the current full output period ends, so no shortened pulse appears. A ratio of 1 with the /16 stage off gives a gated copy of the bus clock.

Top module: `clkout_div`

## Requirements
- R1: After reset the register reads 0x80 (bit 7, the disable bit, is 1; all other bits are 0) and clk_o is low.
- R2: Register bit 7 (disable), bit 5 (divide-by-16 enable) and bits 4..0 (ratio field F) read back as last written; bit 6 always reads 0 and ignores writes.
- R3: With bit 7 = 0, bit 5 = 0 and F >= 1, clk_o has a period of N = F+1 bus cycles and is high for floor(N/2) of them.
- R4: With bit 7 = 0, bit 5 = 0 and F = 0, clk_o is high during the high half of every bus clock cycle and low during the low half.
- R5: With bit 7 = 0 and bit 5 = 1, clk_o has a period of 16*(F+1) bus cycles and is high for 8*(F+1) of them.
- R6: Once bit 7 = 1 has been written, clk_o is low from the second rising bus-clock edge after the write onward, and both divider counters are at zero.
- R7: A write that clears bit 7 from the disabled state makes clk_o rise one bus cycle after the write edge, using the ratio and stage setting carried by that write.
- R8: A ratio or stage change written while the output runs takes effect only at the end of the current full output period. The period in progress keeps its old length.
- R9: The divide-by-16 counter advances only on a terminal count of the ratio counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| clk_o | output | 1 | Divided clock output |

## Verification
A register write commits on the rising edge at which the strobe is seen, and the read data shows it from that edge on. The bench therefore reads it back one nanosecond after that edge. clk_o is registered one stage behind the counters: after an enabling write at edge E it rises at edge E+1, and after a disabling write at edge D it is low from edge D+1. The bench samples at E and E+1 and checks quiet from D+2 on. A new ratio becomes visible only after the running period ends. A background sampler therefore reads clk_o one nanosecond after every clock edge, both rising and falling, and times whole periods between rising edges in half-cycles. Each measurement discards the first rising edge after a write, so the period checked lies wholly under the new setting.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;
  localparam int REG_W   = 8;
  localparam int OFF_BIT = 7;
  localparam int PRE_BIT = 5;
  localparam int DIV_W   = 5;
  localparam int PRE_W   = 4;
endpackage

// File: rtl/clkout_div_reg.sv
module clkout_div_reg
  import clkout_div_pkg::*;
#(
  parameter int DIV_W_P = DIV_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic               off_o,
  output logic               nxt_pre_o,
  output logic [DIV_W_P-1:0] nxt_ratio_o,
  output logic [REG_W-1:0]   rd_data_o
);
  logic               off_q, pre_q;
  logic [DIV_W_P-1:0] ratio_q;
  logic               off_d;

  always_comb begin
    off_d       = wr_en_i ? wr_data_i[OFF_BIT]       : off_q;
    nxt_pre_o   = wr_en_i ? wr_data_i[PRE_BIT]       : pre_q;
    nxt_ratio_o = wr_en_i ? wr_data_i[DIV_W_P-1:0]   : ratio_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= 1'b1;
      pre_q   <= 1'b0;
      ratio_q <= '0;
    end else begin
      off_q   <= off_d;
      pre_q   <= nxt_pre_o;
      ratio_q <= nxt_ratio_o;
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[OFF_BIT]       = off_q;
    rd_data_o[PRE_BIT]       = pre_q;
    rd_data_o[DIV_W_P-1:0]   = ratio_q;
  end

  assign off_o = off_q;
endmodule

// File: rtl/clkout_div_base.sv
module clkout_div_base #(
  parameter int DIV_W_P = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [DIV_W_P-1:0] limit_i,
  output logic               tc_o,
  output logic [DIV_W_P-1:0] cnt_o
);
  logic [DIV_W_P-1:0] cnt_q;

  assign tc_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tc_o)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/clkout_div_post.sv
module clkout_div_post #(
  parameter int PRE_W_P = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               en_i,
  input  logic               step_i,
  output logic               wrap_o,
  output logic               msb_o,
  output logic [PRE_W_P-1:0] cnt_o
);
  logic [PRE_W_P-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (en_i && step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = &cnt_q;
  assign msb_o  = cnt_q[PRE_W_P-1];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/clkout_div_out.sv
module clkout_div_out #(
  parameter int DIV_W_P = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               pre_en_i,
  input  logic [DIV_W_P-1:0] ratio_i,
  input  logic [DIV_W_P-1:0] cnt_i,
  input  logic               post_msb_i,
  output logic               clk_o
);
  logic [DIV_W_P:0] n_w, half_w;
  logic             hi_w, out_q, byp_n_q;

  always_comb begin
    n_w    = {1'b0, ratio_i} + (DIV_W_P+1)'(1);
    half_w = n_w >> 1;
    hi_w   = pre_en_i ? !post_msb_i : ({1'b0, cnt_i} < half_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= run_i && hi_w;
  end

  // gate enable updated while clk_i is low so the bypass path cannot chop a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_n_q <= 1'b0;
    else         byp_n_q <= run_i && !pre_en_i && (ratio_i == '0);
  end

  assign clk_o = out_q | (clk_i & byp_n_q);
endmodule

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_div_pkg::*;
#(
  parameter int DIV_W_P = DIV_W,
  parameter int PRE_W_P = PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             clk_o
);
  logic               off, run, nxt_pre;
  logic [DIV_W_P-1:0] nxt_ratio, act_ratio, base_cnt;
  logic               act_pre, base_tc, post_wrap, post_msb, period_end;
  logic [PRE_W_P-1:0] post_cnt;

  clkout_div_reg #(.DIV_W_P(DIV_W_P)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .off_o(off), .nxt_pre_o(nxt_pre), .nxt_ratio_o(nxt_ratio), .rd_data_o
  );

  assign run        = !off;
  assign period_end = base_tc && (!act_pre || post_wrap);

  // active setting: tracks the register while idle, else swaps only at period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ratio <= '0;
      act_pre   <= 1'b0;
    end else if (!run || period_end) begin
      act_ratio <= nxt_ratio;
      act_pre   <= nxt_pre;
    end
  end

  clkout_div_base #(.DIV_W_P(DIV_W_P)) u_base (
    .clk_i, .rst_ni, .run_i(run), .limit_i(act_ratio),
    .tc_o(base_tc), .cnt_o(base_cnt)
  );

  clkout_div_post #(.PRE_W_P(PRE_W_P)) u_post (
    .clk_i, .rst_ni, .run_i(run), .en_i(act_pre), .step_i(base_tc),
    .wrap_o(post_wrap), .msb_o(post_msb), .cnt_o(post_cnt)
  );

  clkout_div_out #(.DIV_W_P(DIV_W_P)) u_out (
    .clk_i, .rst_ni, .run_i(run), .pre_en_i(act_pre), .ratio_i(act_ratio),
    .cnt_i(base_cnt), .post_msb_i(post_msb), .clk_o
  );
endmodule

// File: rtl/clkout_div_chk.sv
module clkout_div_chk #(
  parameter int DIV_W_P = 5,
  parameter int PRE_W_P = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [7:0]         rd_data_o,
  input logic               clk_o,
  input logic               run,
  input logic               base_tc,
  input logic               period_end,
  input logic               act_pre,
  input logic [DIV_W_P-1:0] act_ratio,
  input logic [DIV_W_P-1:0] base_cnt,
  input logic [PRE_W_P-1:0] post_cnt
);
  p_bit6_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[6] == 1'b0);

  p_off_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !$past(run)) |-> !clk_o);

  p_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run) |-> (base_cnt == '0 && post_cnt == '0));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> base_cnt <= act_ratio);

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run) && !$past(period_end)) |-> ($stable(act_ratio) && $stable(act_pre)));

  p_post_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run) && !$past(base_tc)) |-> $stable(post_cnt));
endmodule

bind clkout_div clkout_div_chk #(.DIV_W_P(DIV_W_P), .PRE_W_P(PRE_W_P)) u_chk (
  .clk_i, .rst_ni, .rd_data_o, .clk_o, .run, .base_tc, .period_end,
  .act_pre, .act_ratio, .base_cnt, .post_cnt
);

// File: tb/clkout_div_bench.sv
module clkout_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       clk_o;

  int checks = 0;
  int fails  = 0;

  clkout_div u_clkout_div (.clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o, .clk_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // half-cycle sampler: one sample 1 ns after each edge
  int hidx = 0, rise_last = 0, rise_prev = 0, hi_acc = 0, last_hi = 0, nrise = 0;
  bit prev_s = 1'b0;
  always @(posedge clk_i or negedge clk_i) begin
    #1;
    hidx++;
    if (clk_o && !prev_s) begin
      rise_prev = rise_last;
      rise_last = hidx;
      last_hi   = hi_acc;
      hi_acc    = 0;
      nrise++;
    end
    if (clk_o) hi_acc++;
    prev_s = clk_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic reg_wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i   = 1'b0;
  endtask

  task automatic wait_rises(input int k);
    int n0 = nrise;
    while (nrise < n0 + k) @(posedge clk_i);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 reg reset", int'(rd_data_o), 8'h80);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); #1;
      chk("R1 clk_o low", int'(clk_o), 0);
      if (clk_o) break;
    end
  endtask

  task automatic t_readback();
    reg_wr(8'hFF);
    chk("R2 readback ff", int'(rd_data_o), 8'hBF);
    reg_wr(8'hF5);
    chk("R2 readback f5", int'(rd_data_o), 8'hB5);
    reg_wr(8'h4A);
    chk("R2 readback 4a", int'(rd_data_o), 8'h0A);
    reg_wr(8'h80);
    chk("R2 readback 80", int'(rd_data_o), 8'h80);
  endtask

  task automatic t_sweep(input bit pre);
    for (int f = 0; f < 32; f++) begin
      int n = f + 1;
      int exp_per, exp_hi;
      string tag;
      reg_wr({2'b00, pre, 5'(f)});
      wait_rises(3);
      exp_per = pre ? 32 * n : 2 * n;
      exp_hi  = pre ? 16 * n : ((n == 1) ? 1 : 2 * (n / 2));
      tag = pre ? "R5" : ((f == 0) ? "R4" : "R3");
      chk($sformatf("%s period f=%0d (half-cycles)", tag, f), rise_last - rise_prev, exp_per);
      chk($sformatf("%s high f=%0d (half-cycles)", tag, f), last_hi, exp_hi);
    end
  endtask

  task automatic t_disable_enable();
    int highs = 0;
    reg_wr(8'h03);
    wait_rises(2);
    reg_wr(8'h83);                 // now 1 ns after the write edge D
    @(posedge clk_i); #1;          // D+1
    for (int i = 0; i < 40; i++) begin
      @(posedge clk_i or negedge clk_i); #1;
      if (clk_o) highs++;
    end
    chk("R6 quiet while disabled", highs, 0);
    chk("R6 reg holds 83", int'(rd_data_o), 8'h83);
    reg_wr(8'h05);                 // enable, N=6, at edge E
    chk("R7 low at write edge", int'(clk_o), 0);
    @(posedge clk_i); #1;
    chk("R7 high one cycle after", int'(clk_o), 1);
    wait_rises(2);
    chk("R7 period uses written ratio", rise_last - rise_prev, 12);
    reg_wr(8'h80);
    @(posedge clk_i);
    reg_wr(8'h21);                 // enable with /16 stage, N=2
    chk("R7 low at write edge (div16)", int'(clk_o), 0);
    @(posedge clk_i); #1;
    chk("R7 high one cycle after (div16)", int'(clk_o), 1);
  endtask

  task automatic t_reconfig();
    reg_wr(8'h80);
    reg_wr(8'h07);
    wait_rises(2);
    reg_wr(8'h01);                 // mid-period change to N=2
    wait_rises(1);
    chk("R8 current period kept", rise_last - rise_prev, 16);
    chk("R8 current high kept", last_hi, 8);
    wait_rises(1);
    chk("R8 new period", rise_last - rise_prev, 4);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    #(3 * CLK_PERIOD + 2);
    chk("R1 reg in reset", int'(rd_data_o), 8'h80);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_readback();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_disable_enable();
    t_reconfig();
    summary();
    $finish;
  end
endmodule